// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer events into the five-byte packet stream that a mouse on a serial line sends. A single event carries three signed 10-bit motion values (horizontal, vertical, wheel) and three button states. The block encodes each event as one packet. The first byte carries the buttons, active low. The second byte is the horizontal motion, limited to a signed byte. The third byte is the vertical motion with its sign reversed and limited the same way. Two zero bytes complete the packet.

Packets are written into a byte FIFO with 256 entries. A receive channel drains the FIFO one byte per host read, and the FIFO's not-empty flag serves as that channel's "character available" indication.

Events enter on a valid/ready handshake. While a packet is being written, `ev_ready` stays low, so an upstream source must hold its event until `ev_ready` returns high. An event is taken on any cycle in which both `ev_valid` and `ev_ready` are high. The read side is a plain strobe. A byte is taken on every cycle in which `rd_take` is high, and `rd_byte` is valid in that same cycle.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when the left button (`ev_btn[2]`) is pressed, bit 1 cleared for the middle button (`ev_btn[1]`) and bit 0 cleared for the right button (`ev_btn[0]`).
- R2: The second byte is `ev_dx` limited to the range -127..+127, in two's complement; -128 and below give 0x81, and +128 and above give 0x7F.
- R3: The third byte is the negation of `ev_dy`, limited to -127..+127, in two's complement.
- R4: The fourth and fifth bytes of every packet are 0x00.
- R5: An event with all three motion values zero and no button pressed is accepted and discarded, without writing any byte and without lowering `ev_ready`. An event with only wheel motion still produces a packet.
- R6: The FIFO holds 256 bytes. A byte written while the FIFO holds 256 bytes and no read is taken is dropped, and the stored contents are unchanged.
- R7: While the FIFO is empty, `rd_avail` is 0 and `rd_byte` is 0x00. A read strobe in that state has no effect.
- R8: After a read, `rd_avail` stays 1 while bytes remain, and the bytes come out in the order they were written.
- R9: An accepted non-discarded event writes its five bytes on five consecutive clock edges, starting at the edge after acceptance. `ev_ready` is low during exactly those five cycles.
- R10: A write and a read on the same clock edge both take effect: the FIFO level is unchanged and no byte is lost or repeated.
- R11: After reset the FIFO is empty (`rd_avail` = 0, `rd_byte` = 0x00) and `ev_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be taken (low while a packet is written) |
| ev_dx | input | 10 | Horizontal motion, signed |
| ev_dy | input | 10 | Vertical motion, signed |
| ev_dz | input | 10 | Wheel motion, signed (only used to decide whether the event is discarded) |
| ev_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| rd_take | input | 1 | Host read strobe, removes the head byte |
| rd_byte | output | 8 | Head byte of the FIFO, 0x00 when empty |
| rd_avail | output | 1 | FIFO not empty |

## Verification
A packet being written into the FIFO and a host read removing a byte can fall on the same clock edge. The bench provokes this by preloading two packets. It then sends a new event while it issues a read on every cycle, so all five packet writes coincide with pops. The scoreboard compares every byte read against the expected order and finally drains the FIFO, which must hold exactly the leftover preloaded bytes followed by the new packet.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  typedef logic [7:0] byte_t;

  localparam int BTN_W    = 3;
  localparam int HDR_BASE = 8'h87;

  // Header byte: fixed marker with each pressed button clearing its bit.
  function automatic byte_t hdr_byte(input logic [BTN_W-1:0] pressed);
    hdr_byte = byte_t'(HDR_BASE) & ~{{(8-BTN_W){1'b0}}, pressed};
  endfunction
endpackage

// File: rtl/mpe_axis_clip.sv
module mpe_axis_clip #(
  parameter int IW  = 10,
  parameter int OW  = 8,
  parameter bit NEG = 1'b0
) (
  input  logic [IW-1:0] raw,
  output logic [OW-1:0] clipped
);
  localparam int LIM = (2 ** (OW - 1)) - 1;

  logic signed [IW:0] ext;
  logic signed [IW:0] pos_lim;
  logic signed [IW:0] neg_lim;

  generate
    if (NEG) begin : g_neg
      assign ext = -$signed({raw[IW-1], raw});
    end else begin : g_pos
      assign ext = $signed({raw[IW-1], raw});
    end
  endgenerate

  assign pos_lim = (IW+1)'(LIM);
  assign neg_lim = -pos_lim;

  always_comb begin
    if (ext > pos_lim)      clipped = pos_lim[OW-1:0];
    else if (ext < neg_lim) clipped = neg_lim[OW-1:0];
    else                    clipped = ext[OW-1:0];
  end
endmodule

// File: rtl/mpe_packer.sv
module mpe_packer
  import mpe_pkg::*;
#(
  parameter int MW      = 10,
  parameter int PKT_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [MW-1:0]    ev_dx,
  input  logic [MW-1:0]    ev_dy,
  input  logic [MW-1:0]    ev_dz,
  input  logic [BTN_W-1:0] ev_btn,
  input  byte_t            x_byte,
  input  byte_t            y_byte,
  output logic             push,
  output byte_t            push_byte
);
  localparam int CW = $clog2(PKT_LEN + 1);
  localparam int SW = 8 * PKT_LEN;

  logic [CW-1:0] left;
  logic [SW-1:0] shreg;
  logic [SW-1:0] frame;
  logic          is_null;
  logic          take;

  assign is_null = (ev_dx == '0) && (ev_dy == '0) && (ev_dz == '0) && (ev_btn == '0);
  assign ev_ready = (left == '0);
  assign take     = ev_valid && ev_ready && !is_null;

  // Byte 0 leaves first; trailing bytes stay zero.
  always_comb begin
    frame         = '0;
    frame[7:0]    = hdr_byte(ev_btn);
    frame[15:8]   = x_byte;
    frame[23:16]  = y_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= '0;
      shreg <= '0;
    end else if (take) begin
      left  <= CW'(PKT_LEN);
      shreg <= frame;
    end else if (left != '0) begin
      left  <= left - 1'b1;
      shreg <= shreg >> 8;
    end
  end

  assign push      = (left != '0);
  assign push_byte = shreg[7:0];
endmodule

// File: rtl/mpe_byte_fifo.sv
module mpe_byte_fifo
  import mpe_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  byte_t                      push_byte,
  input  logic                       pop,
  output byte_t                      head,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic          pop_ok;
  logic          push_ok;

  assign not_empty = (fill != '0);
  assign pop_ok    = pop && not_empty;
  assign push_ok   = push && ((fill != FW'(DEPTH)) || pop_ok);
  assign head      = not_empty ? mem[rptr] : 8'h00;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int MW         = 10,
  parameter int PKT_LEN    = 5,
  parameter int FIFO_DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [MW-1:0]    ev_dx,
  input  logic [MW-1:0]    ev_dy,
  input  logic [MW-1:0]    ev_dz,
  input  logic [BTN_W-1:0] ev_btn,
  input  logic             rd_take,
  output logic [7:0]       rd_byte,
  output logic             rd_avail
);
  localparam int FW = $clog2(FIFO_DEPTH + 1);

  byte_t         x_byte;
  byte_t         y_byte;
  logic          pk_push;
  byte_t         pk_byte;
  logic [FW-1:0] fifo_fill;

  mpe_axis_clip #(.IW(MW), .OW(8), .NEG(1'b0)) u_clip_x (
    .raw(ev_dx), .clipped(x_byte)
  );

  mpe_axis_clip #(.IW(MW), .OW(8), .NEG(1'b1)) u_clip_y (
    .raw(ev_dy), .clipped(y_byte)
  );

  mpe_packer #(.MW(MW), .PKT_LEN(PKT_LEN)) u_packer (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_dz(ev_dz), .ev_btn(ev_btn),
    .x_byte(x_byte), .y_byte(y_byte),
    .push(pk_push), .push_byte(pk_byte)
  );

  mpe_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(pk_push), .push_byte(pk_byte),
    .pop(rd_take),
    .head(rd_byte), .not_empty(rd_avail), .fill(fifo_fill)
  );
endmodule

// File: rtl/mpe_check.sv
module mpe_check #(
  parameter int MW    = 10,
  parameter int DEPTH = 256
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ev_valid,
  input logic                       ev_ready,
  input logic [MW-1:0]              ev_dx,
  input logic [MW-1:0]              ev_dy,
  input logic [MW-1:0]              ev_dz,
  input logic [2:0]                 ev_btn,
  input logic                       rd_take,
  input logic [7:0]                 rd_byte,
  input logic                       rd_avail,
  input logic                       push,
  input logic [7:0]                 push_byte,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  logic ev_null;
  assign ev_null = (ev_dx == '0) && (ev_dy == '0) && (ev_dz == '0) && (ev_btn == '0);

  p_hdr_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push) |-> push_byte[7:3] == 5'b10000);

  p_null_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_null |=> ev_ready && !push);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == ($clog2(DEPTH+1))'(DEPTH)) && !rd_take |=> fill == ($clog2(DEPTH+1))'(DEPTH));

  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_avail |-> rd_byte == 8'h00);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take && !rd_avail && !push |=> !rd_avail);

  p_remaining_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take && (fill > 1) |=> rd_avail);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !ev_null |=> !ev_ready && push);

  p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push && rd_take && (fill != '0) |=> $stable(fill));
endmodule

bind mouse_pkt_enc mpe_check #(.MW(MW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_dz(ev_dz), .ev_btn(ev_btn),
  .rd_take(rd_take), .rd_byte(rd_byte), .rd_avail(rd_avail),
  .push(pk_push), .push_byte(pk_byte), .fill(fifo_fill)
);

// File: tb/tb_mouse_pkt_enc.sv
module tb_mouse_pkt_enc;
  // 1 time unit = 1 ns; 4 ns period = 250 MHz
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [9:0] ev_dx = '0;
  logic [9:0] ev_dy = '0;
  logic [9:0] ev_dz = '0;
  logic [2:0] ev_btn = '0;
  logic       rd_take = 1'b0;
  logic [7:0] rd_byte;
  logic       rd_avail;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  mouse_pkt_enc dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_dz(ev_dz), .ev_btn(ev_btn),
    .rd_take(rd_take), .rd_byte(rd_byte), .rd_avail(rd_avail)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clip(input int v);
    int r;
    r = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return 8'(r);
  endfunction

  function automatic void exp_add(input logic [7:0] b);
    if (exp_q.size() < 256) exp_q.push_back(b);
  endfunction

  // Driver: hands one event to the design and records the expected bytes.
  task automatic send_evt(input int dx, input int dy, input int dz,
                          input logic [2:0] btn, input bit watch_busy);
    bit nul;
    nul = (dx == 0) && (dy == 0) && (dz == 0) && (btn == 3'b000);
    @(negedge clk);
    ev_dx = 10'(dx); ev_dy = 10'(dy); ev_dz = 10'(dz); ev_btn = btn;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(posedge clk);
    #1 ev_valid = 1'b0;
    if (!nul) begin
      exp_add(8'h87 & ~{5'b0, btn});
      exp_add(clip(dx));
      exp_add(clip(-dy));
      exp_add(8'h00);
      exp_add(8'h00);
    end
    if (watch_busy) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(nul ? "R5 ready after null" : "R9 busy window", int'(ev_ready), nul ? 1 : 0);
        if (nul) break;
      end
      if (!nul) begin
        @(negedge clk);
        check("R9 ready after five bytes", int'(ev_ready), 1);
      end
    end
  endtask

  // Monitor: one host read, compared against the scoreboard head.
  task automatic rd_one(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
    check({req, " avail"}, int'(rd_avail), (e !== 8'hxx && rd_avail_expected(e)) ? 1 : 0);
    check({req, " byte"}, int'(rd_byte), int'(e));
    rd_take = 1'b1;
    @(posedge clk);
    #1 rd_take = 1'b0;
  endtask

  bit last_nonempty;
  function automatic bit rd_avail_expected(input logic [7:0] e);
    return last_nonempty;
  endfunction

  task automatic rd_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      last_nonempty = (exp_q.size() != 0);
      rd_one(req);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 avail", int'(rd_avail), 0);
    check("R11 byte", int'(rd_byte), 0);
    check("R11 ready", int'(ev_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R9: basic packet, left button, small motion
    send_evt(5, 3, 0, 3'b100, 1'b1);
    check("R8 avail after packet", int'(rd_avail), 1);
    rd_n(5, "R1 R2 R3 R4 basic");
    // R7: empty read returns zero and changes nothing
    rd_n(2, "R7 empty read");

    // R2 R3: saturation corners and R1 other buttons
    send_evt(300, -400, 0, 3'b010, 1'b0);
    send_evt(-512, 511, 0, 3'b001, 1'b0);
    send_evt(127, -127, 0, 3'b111, 1'b0);
    send_evt(-128, 128, 7, 3'b000, 1'b0);
    send_evt(-1, 1, 0, 3'b011, 1'b0);
    repeat (6) @(negedge clk);
    rd_n(25, "R2 R3 saturation");
    rd_n(1, "R7 empty after drain");

    // R5: null event discarded; wheel-only event still packs
    send_evt(0, 0, 0, 3'b000, 1'b1);
    check("R5 no byte after null", int'(rd_avail), 0);
    send_evt(0, 0, -3, 3'b000, 1'b1);
    rd_n(5, "R5 wheel only");

    // R10: packet writes collide with reads on the same edges
    send_evt(10, 20, 0, 3'b000, 1'b0);
    send_evt(-30, -40, 0, 3'b110, 1'b0);
    repeat (6) @(negedge clk);
    fork
      send_evt(64, -64, 0, 3'b101, 1'b0);
      rd_n(8, "R10 read during write");
    join
    repeat (6) @(negedge clk);
    rd_n(7, "R10 remainder");
    rd_n(1, "R7 empty after collide");

    // R6 R8: fill beyond capacity, no reads
    for (int i = 0; i < 52; i++) send_evt(i + 1, -(i + 2), 0, 3'(i), 1'b0);
    repeat (8) @(negedge clk);
    rd_n(256, "R6 R8 full drain");
    rd_n(1, "R6 R7 empty after full");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule